// File: doc/BRIEF.md
# Core sleep-state sequencer

This block moves one processor core from the active state into an idle sleep level and back again. An idle request carries a target depth: light halt, clock-stopped with flushed cache, or state-saved power-off. The block then works through an ordered list of actions up to that depth. It raises one action request at a time and waits for that action's done handshake before it raises the next one.

A wake event releases the completed actions in the reverse order. After the power switch closes, the block waits a programmable number of settle cycles before it starts the state restore. A wake that arrives while the block is still entering lets the step in flight finish, and then the block unwinds from that point.

The two deeper levels are allowed only when the core runs at its lowest performance state. Until then the request is held. The block reports the current sleep depth and a busy flag.

Top module: `core_idle_seq`

## Requirements
- R1: After reset, act_req_o is all zero, depth_o is 0 and busy_o is low.
- R2: Depth codes on req_depth_i and depth_o are 0 = active, 1 = light halt, 2 = clock-stopped, 3 = power-off. These levels raise action steps 0..1, 0..3 and 0..5 respectively. depth_o shows the level whose steps are all in effect. A request with code 0 starts nothing.
- R3: Action steps, by act_req_o bit, are: 0 halt pipeline, 1 gate most core clocks, 2 flush private cache, 3 gate remaining clocks, 4 save architectural state, 5 open power switch. They are raised in ascending order, and step k rises only after act_done_i[k-1] is observed high.
- R4: At the light-halt level, steps 2 and 3 are never raised, so the cache clock stays on and snoops can still be served.
- R5: On wake, the raised steps are released in descending order. Step k is released only after act_done_i[k+1] is observed low. The block returns to depth 0 with every request low.
- R6: After act_done_i[5] falls, the release of step 4 (state restore) waits at least settle_cycles_i clock cycles.
- R7: A wake during entry lets the step in flight complete. No further step is raised, and the unwind starts from the deepest completed step.
- R8: A request for depth 2 or 3 while pstate_min_i is low raises no step, and busy_o stays low, until pstate_min_i goes high. A wake cancels such a held request.
- R9: busy_o is high for the whole of an entry or exit, and low while idle in C0 or resident at a level. While busy_o is low, act_req_o does not change.
- R10: A request made while resident or busy is ignored. A wake while idle with no held request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle idle request strobe |
| req_depth_i | input | 2 | Target depth code of the request |
| pstate_min_i | input | 1 | Core is at its lowest performance state |
| wake_i | input | 1 | Wake event |
| settle_cycles_i | input | SETTLE_W | Settle delay after the power switch closes |
| act_done_i | input | 6 | Per-step done handshake from the action units |
| act_req_o | output | 6 | Per-step action request, held high while the action applies |
| depth_o | output | 2 | Current depth code |
| busy_o | output | 1 | Transition in progress |

## Verification
The assertions assume that each action unit follows a four-phase handshake. Its act_done_i bit rises only while the matching request is high and falls only after the request drops. Without this, the ordering properties could pass on done edges that the block never asked for. The bench drives act_done_i from a responder model that obeys this rule, with a different latency for each step. It changes pstate_min_i and settle_cycles_i only while the block is idle.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
  localparam int unsigned NSTEP    = 6;
  localparam int unsigned LVL_W    = $clog2(NSTEP + 1);
  localparam int unsigned STEP_PWR = NSTEP - 1;

  typedef enum logic [1:0] {
    DEP_C0 = 2'd0,
    DEP_C1 = 2'd1,
    DEP_C3 = 2'd2,
    DEP_C6 = 2'd3
  } depth_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_RESIDENT,
    ST_EXIT,
    ST_SETTLE
  } seq_st_e;

  // number of action steps a depth needs
  function automatic logic [LVL_W-1:0] steps_for(depth_e d);
    case (d)
      DEP_C1:  return LVL_W'(2);
      DEP_C3:  return LVL_W'(4);
      DEP_C6:  return LVL_W'(NSTEP);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cidle_req_hold.sv
module cidle_req_hold
  import cidle_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_en_i,
  input  logic   req_valid_i,
  input  depth_e req_depth_i,
  input  logic   pstate_min_i,
  input  logic   wake_i,
  input  logic   take_i,
  output logic   go_o,
  output depth_e go_depth_o
);
  logic   pend_q;
  depth_e pend_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_d_q <= DEP_C0;
    end else if (take_i || wake_i) begin
      pend_q <= 1'b0;
    end else if (accept_en_i && req_valid_i && req_depth_i != DEP_C0) begin
      pend_q   <= 1'b1;
      pend_d_q <= req_depth_i;
    end
  end

  // deep levels wait for the lowest performance state
  assign go_o       = pend_q && (pend_d_q == DEP_C1 || pstate_min_i);
  assign go_depth_o = pend_d_q;
endmodule

// File: rtl/cidle_settle_timer.sv
module cidle_settle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cidle_depth_enc.sv
module cidle_depth_enc
  import cidle_pkg::*;
(
  input  logic [LVL_W-1:0] lvl_i,
  output depth_e           depth_o
);
  always_comb begin
    if (lvl_i >= steps_for(DEP_C6))      depth_o = DEP_C6;
    else if (lvl_i >= steps_for(DEP_C3)) depth_o = DEP_C3;
    else if (lvl_i >= steps_for(DEP_C1)) depth_o = DEP_C1;
    else                                 depth_o = DEP_C0;
  end
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cidle_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_depth_i,
  input  logic                pstate_min_i,
  input  logic                wake_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic [NSTEP-1:0]    act_done_i,
  output logic [NSTEP-1:0]    act_req_o,
  output logic [1:0]          depth_o,
  output logic                busy_o
);
  seq_st_e          state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d, tgt_q, tgt_d, dn_idx;
  logic [NSTEP-1:0] req_q, req_d;
  logic             abort_q, abort_d;
  logic             go, start, load, expired;
  depth_e           go_depth, depth_enc;

  cidle_req_hold u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_en_i  (state_q == ST_IDLE),
    .req_valid_i  (req_valid_i),
    .req_depth_i  (depth_e'(req_depth_i)),
    .pstate_min_i (pstate_min_i),
    .wake_i       (wake_i),
    .take_i       (start),
    .go_o         (go),
    .go_depth_o   (go_depth)
  );

  cidle_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (settle_cycles_i),
    .expired_o  (expired)
  );

  cidle_depth_enc u_enc (
    .lvl_i   (lvl_q),
    .depth_o (depth_enc)
  );

  assign dn_idx = lvl_q - LVL_W'(1);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    tgt_d   = tgt_q;
    req_d   = req_q;
    abort_d = abort_q;
    load    = 1'b0;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go && !wake_i) begin
          start    = 1'b1;
          req_d[0] = 1'b1;
          lvl_d    = '0;
          tgt_d    = steps_for(go_depth);
          abort_d  = 1'b0;
          state_d  = ST_ENTER;
        end
      end
      ST_ENTER: begin
        abort_d = abort_q | wake_i;
        if (act_done_i[lvl_q]) begin
          lvl_d = lvl_q + LVL_W'(1);
          if (abort_d) begin
            // in-flight step done: unwind from here
            req_d[lvl_q] = 1'b0;
            state_d      = ST_EXIT;
          end else if (lvl_d == tgt_q) begin
            state_d = ST_RESIDENT;
          end else begin
            req_d[lvl_d] = 1'b1;
          end
        end
      end
      ST_RESIDENT: begin
        if (wake_i) begin
          req_d[dn_idx] = 1'b0;
          state_d       = ST_EXIT;
        end
      end
      ST_EXIT: begin
        if (!act_done_i[dn_idx]) begin
          if (dn_idx == LVL_W'(STEP_PWR)) begin
            load    = 1'b1;
            state_d = ST_SETTLE;
          end else begin
            lvl_d = dn_idx;
            if (dn_idx == '0) state_d = ST_IDLE;
            else              req_d[dn_idx - LVL_W'(1)] = 1'b0;
          end
        end
      end
      ST_SETTLE: begin
        if (expired) begin
          lvl_d                     = dn_idx;
          req_d[dn_idx - LVL_W'(1)] = 1'b0;
          state_d                   = ST_EXIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      tgt_q   <= '0;
      req_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      tgt_q   <= tgt_d;
      req_q   <= req_d;
      abort_q <= abort_d;
    end
  end

  assign act_req_o = req_q;
  assign depth_o   = depth_enc;
  assign busy_o    = (state_q == ST_ENTER) || (state_q == ST_EXIT) || (state_q == ST_SETTLE);
endmodule

// File: rtl/cidle_seq_chk.sv
module cidle_seq_chk
  import cidle_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSTEP-1:0] act_req_o,
  input logic [NSTEP-1:0] act_done_i,
  input logic [1:0]       depth_o,
  input logic             busy_o
);
  for (genvar k = 1; k < NSTEP; k++) begin : g_up
    a_r3_entry_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_req_o[k]) |-> ($past(act_done_i[k-1]) && act_req_o[k-1]));
    a_r2_thermometer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_req_o[k] |-> act_req_o[k-1]);
  end

  for (genvar k = 0; k < NSTEP - 1; k++) begin : g_dn
    a_r5_release_after_undo: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(act_req_o[k]) |-> (!$past(act_done_i[k+1]) && !act_req_o[k+1]));
  end

  a_r9_quiet_when_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $stable(act_req_o));

  a_r9_idle_all_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && depth_o == 2'd0) |-> (act_req_o == '0));

  a_r4_c1_keeps_cache_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && depth_o == 2'd1) |-> (!act_req_o[2] && !act_req_o[3]));
endmodule

bind core_idle_seq cidle_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_req_o  (act_req_o),
  .act_done_i (act_done_i),
  .depth_o    (depth_o),
  .busy_o     (busy_o)
);

// File: tb/tb_core_idle_seq.sv
`timescale 1ns/1ps
module tb_core_idle_seq;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_depth = 2'd0;
  logic          pstate_min = 1'b0;
  logic          wake = 1'b0;
  logic [7:0]    settle = 8'd4;
  logic [NS-1:0] act_done = '0;
  logic [NS-1:0] act_req;
  logic [1:0]    depth;
  logic          busy;

  int checks = 0, errors = 0, cyc = 0, t_pwr_off = 0;
  int dly[NS];
  int cnt[NS];
  int ev[$];
  int evc[$];
  logic [NS-1:0] prev = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  core_idle_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_depth_i(req_depth),
    .pstate_min_i(pstate_min), .wake_i(wake), .settle_cycles_i(settle),
    .act_done_i(act_done), .act_req_o(act_req), .depth_o(depth), .busy_o(busy)
  );

  // monitor and action-unit responder
  initial begin
    for (int k = 0; k < NS; k++) begin dly[k] = k + 2; cnt[k] = 0; end
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_ni) begin
        prev = '0; act_done = '0;
      end else begin
        for (int k = 0; k < NS; k++)
          if (act_req[k] != prev[k]) begin
            ev.push_back(act_req[k] ? k + 1 : -(k + 1));
            evc.push_back(cyc);
          end
        prev = act_req;
        for (int k = 0; k < NS; k++) begin
          if (act_done[k] != act_req[k]) begin
            cnt[k]++;
            if (cnt[k] >= dly[k]) begin
              act_done[k] = act_req[k];
              cnt[k] = 0;
              if (k == NS - 1 && !act_req[k]) t_pwr_off = cyc;
            end
          end else cnt[k] = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_log(input string r, input int exp[$]);
    chk(ev.size() == exp.size(), {r, " event count"}, ev.size(), exp.size());
    for (int i = 0; i < exp.size() && i < ev.size(); i++)
      chk(ev[i] == exp[i], {r, " event order"}, ev[i], exp[i]);
  endtask

  task automatic send_req(input logic [1:0] d);
    @(negedge clk); req_valid = 1'b1; req_depth = d;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic wait_settled();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(act_req == '0, "R1 requests after reset", act_req, 0);
    chk(depth == 2'd0, "R1 depth after reset", depth, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_light_halt();
    ev.delete(); evc.delete();
    pstate_min = 1'b0;
    send_req(2'd1);
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy during entry", busy, 1);
    wait_settled();
    chk(depth == 2'd1, "R2 light-halt depth", depth, 1);
    chk(act_req == 6'b000011, "R2 light-halt steps", act_req, 6'b000011);
    chk(act_req[3] == 1'b0, "R4 cache clock kept", act_req[3], 0);
    chk(busy == 1'b0, "R9 busy low when resident", busy, 0);
    chk_log("R3", '{1, 2});
    pulse_wake();
    wait_settled();
    chk(depth == 2'd0 && act_req == '0, "R5 back to active", act_req, 0);
    chk_log("R5", '{1, 2, -2, -1});
  endtask

  task automatic t_held_deep();
    ev.delete(); evc.delete();
    pstate_min = 1'b0;
    send_req(2'd2);
    repeat (20) @(negedge clk);
    chk(act_req == '0, "R8 held request raises nothing", act_req, 0);
    chk(busy == 1'b0, "R8 busy low while held", busy, 1'b0);
    pstate_min = 1'b1;
    wait_settled();
    chk(depth == 2'd2, "R2 clock-stopped depth", depth, 2);
    chk(act_req == 6'b001111, "R2 clock-stopped steps", act_req, 6'b001111);
    chk_log("R3", '{1, 2, 3, 4});
    pulse_wake();
    wait_settled();
    chk_log("R5", '{1, 2, 3, 4, -4, -3, -2, -1});
    chk(depth == 2'd0, "R5 depth after wake", depth, 0);
  endtask

  task automatic t_power_off();
    int idx;
    ev.delete(); evc.delete();
    pstate_min = 1'b1;
    settle = 8'd10;
    send_req(2'd3);
    wait_settled();
    chk(depth == 2'd3, "R2 power-off depth", depth, 3);
    chk(act_req == 6'b111111, "R2 power-off steps", act_req, 6'b111111);
    chk_log("R3", '{1, 2, 3, 4, 5, 6});
    send_req(2'd1);
    repeat (20) @(negedge clk);
    chk(act_req == 6'b111111 && depth == 2'd3, "R10 request while resident ignored", act_req, 6'b111111);
    pulse_wake();
    wait_settled();
    chk_log("R5", '{1, 2, 3, 4, 5, 6, -6, -5, -4, -3, -2, -1});
    idx = -1;
    for (int i = 0; i < ev.size(); i++) if (ev[i] == -5) idx = i;
    if (idx >= 0) begin
      chk(evc[idx] - t_pwr_off >= 10 && evc[idx] - t_pwr_off <= 13,
          "R6 settle before restore", evc[idx] - t_pwr_off, 12);
    end else chk(1'b0, "R6 restore release seen", 0, 1);
    settle = 8'd4;
  endtask

  task automatic t_abort();
    ev.delete(); evc.delete();
    dly[2] = 30;
    pstate_min = 1'b1;
    send_req(2'd3);
    for (int i = 0; i < 200 && !act_req[2]; i++) @(negedge clk);
    pulse_wake();
    wait_settled();
    chk_log("R7", '{1, 2, 3, -3, -2, -1});
    chk(depth == 2'd0 && act_req == '0, "R7 idle after abort", act_req, 0);
    dly[2] = 4;
  endtask

  task automatic t_ignored();
    ev.delete(); evc.delete();
    pulse_wake();
    repeat (10) @(negedge clk);
    chk(ev.size() == 0 && busy == 1'b0, "R10 wake while idle", ev.size(), 0);
    send_req(2'd0);
    repeat (10) @(negedge clk);
    chk(ev.size() == 0, "R2 code 0 starts nothing", ev.size(), 0);
    pstate_min = 1'b0;
    send_req(2'd3);
    repeat (5) @(negedge clk);
    pulse_wake();
    pstate_min = 1'b1;
    repeat (20) @(negedge clk);
    chk(ev.size() == 0 && act_req == '0, "R8 wake cancels held request", ev.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_light_halt();
    t_held_deep();
    t_power_off();
    t_abort();
    t_ignored();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..R10 run) actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule